// File: doc/BRIEF.md
# RGB Matrix Sub-Row Refresh Sequencer

This block keeps a row-multiplexed RGB LED matrix lit. The matrix is driven by chains of serial greyscale PWM drivers. Every colour line of every bank is a chain of driver chips, each with one 12-bit brightness word per output channel. The sequencer reads brightness words from an external frame memory. It shifts them out on one serial line per colour per bank, and all lines share a single shift clock. It also generates the shared blanking, latch and greyscale clock strobes, and it drives the active-low sub-row enables that all banks share.

After a start pulse, the block first fills the drivers with sub-row 0 while the display is blanked. It then performs a handover: blank, latch, switch the row enable, unblank. After that it issues exactly one PWM period of greyscale clocks. While that period runs, the words for the next sub-row are already shifted into the drivers' input registers. The next handover waits until the period is complete. The sub-rows repeat 0, 1, 2, 3, 0, and so on, and a one-cycle frame pulse marks the start of the last sub-row of each frame.

The frame memory is read combinationally. The block presents `pix_addr` = {sub-row, pixel index}. In the same cycle, the memory returns one 12-bit word per lane on `pix_data`.

Top module: `mtx_refresh_top`

## Requirements
- R1: While reset is active, blank is 1, xlat, sclk, gsclk, frame_done and every sdata bit are 0, and all row enables are 1 (released).
- R2: Each sub-row load gives every lane 576 shift-clock pulses. The pixel index runs from 47 down to 0, and each word is sent from bit 11 down to bit 0. The word comes from `pix_data` lane l = bank*3 + colour (0 red, 1 green, 2 blue), bits [12l+11:12l], read at address {sub-row in bits 7:6, pixel in bits 5:0}.
- R3: The shift clock runs at half the system rate: one cycle high, one cycle low. sdata changes only in a cycle where sclk is low and is stable while sclk is high.
- R4: Handover timing: blank rises; one cycle later xlat goes high; the new row enable appears in the cycle xlat falls; blank falls two cycles after that. Row enables change only while blank is high and was high in the previous cycle.
- R5: xlat is high for exactly two consecutive cycles per handover and only while blank is high.
- R6: Each blank-low window carries exactly 4096 gsclk pulses, each one cycle high and one cycle low. The first pulse is high two cycles after blank falls. gsclk is low whenever blank is high. Blank rises in the cycle after the last pulse.
- R7: The row enables are active low, and at most one is low at any time.
- R8: Sub-rows are shown in the order 0, 1, 2, 3, 0, 1, .... frame_done is high for exactly the first blank-low cycle of sub-row 3.
- R9: Every bank shifts its own lanes from its own words, while all banks share sclk, blank, xlat, gsclk and row enables.
- R10: Before start, the block stays blanked with no sclk or gsclk activity. A start pulse during refresh has no effect on any output.
- R11: The first sub-row is shifted under blank, and its handover begins in the cycle after the 576th shift pulse. Every later load starts together with the PWM window and completes inside it, and its handover waits for the 4096th gsclk pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins continuous refresh when idle |
| pix_addr | output | 8 | Frame memory read address {sub-row, pixel} |
| pix_data | input | 108 | One 12-bit word per lane for the addressed pixel |
| sclk | output | 1 | Shared serial shift clock |
| sdata | output | 9 | Serial data, one bit per lane (bank*3 + colour) |
| gsclk | output | 1 | Shared greyscale PWM clock |
| blank | output | 1 | Shared output blanking, high disables LEDs |
| xlat | output | 1 | Shared latch strobe, input to output register |
| row_en_n | output | 4 | Active-low sub-row enables |
| frame_done | output | 1 | One-cycle pulse when the last sub-row is unblanked |

## Verification
The frame memory content changes at every handover among three patterns, so that each sub-row load uses a different one. A hashed pattern gives every lane, sub-row and pixel a distinct word, which exposes swapped lanes, banks, pixel order or bit order. A pattern with one full-scale pixel per lane and zeros elsewhere shows whether the last word shifted really belongs to pixel 0. A walking-one pattern puts a single set bit at a different position in each word, which shows off-by-one errors in the bit counter. The per-cycle comparison also covers a stray start during refresh and a reset in the middle of a PWM window.

// File: rtl/mtx_refresh_pkg.sv
package mtx_refresh_pkg;

    // Colour lanes carried by one bank: red, green, blue.
    localparam int unsigned LANES_PER_BANK = 3;

    // Handover step numbering (one system clock per step).
    localparam int unsigned HC_W         = 3;
    localparam int unsigned HAND_XLAT_ON = 1;
    localparam int unsigned HAND_ROW_SW  = 3;
    localparam int unsigned HAND_LAST    = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FILL,
        SEQ_HAND,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic blank;
        logic xlat;
    } strobe_t;

    function automatic int unsigned wrap_next(int unsigned cur, int unsigned limit);
        return (cur + 1 >= limit) ? 0 : cur + 1;
    endfunction

    function automatic logic xlat_window(logic [HC_W-1:0] step);
        return (step >= HC_W'(HAND_XLAT_ON)) && (step < HC_W'(HAND_ROW_SW));
    endfunction

endpackage

// File: rtl/mtx_shift_engine.sv
module mtx_shift_engine #(
    parameter int unsigned LINES        = 9,
    parameter int unsigned GS_BITS      = 12,
    parameter int unsigned PIX_PER_LINE = 48,
    localparam int unsigned PIX_W       = $clog2(PIX_PER_LINE),
    localparam int unsigned BIT_W       = $clog2(GS_BITS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       go,
    input  logic [LINES*GS_BITS-1:0]   lane_word,
    output logic [PIX_W-1:0]           pix_idx,
    output logic                       sclk,
    output logic [LINES-1:0]           sdata,
    output logic                       done
);
    localparam int unsigned LINE_BITS = PIX_PER_LINE * GS_BITS;
    localparam int unsigned CNT_W     = $clog2(LINE_BITS + 1);

    logic             active;
    logic             ph;
    logic [PIX_W-1:0] pix_q;
    logic [BIT_W-1:0] bit_q;

    assign pix_idx = pix_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= 1'b0;
            pix_q  <= '0;
            bit_q  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            ph     <= 1'b0;
            pix_q  <= PIX_W'(PIX_PER_LINE - 1);
            bit_q  <= BIT_W'(GS_BITS - 1);
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else if (active) begin
            ph   <= ~ph;
            sclk <= ph;
            if (ph) begin
                if (bit_q == '0) begin
                    bit_q <= BIT_W'(GS_BITS - 1);
                    if (pix_q == '0) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        pix_q <= pix_q - 1'b1;
                    end
                end else begin
                    bit_q <= bit_q - 1'b1;
                end
            end
        end else begin
            sclk <= 1'b0;
        end
    end

    // Data launch: one flop per lane, updated on the low phase.
    for (genvar g = 0; g < LINES; g++) begin : g_lane
        logic [GS_BITS-1:0] word;
        assign word = lane_word[g*GS_BITS +: GS_BITS];
        always_ff @(posedge clk) begin
            if (rst) begin
                sdata[g] <= 1'b0;
            end else if (!go && active && !ph) begin
                sdata[g] <= word[bit_q];
            end
        end
    end

    // Checker state: shift pulses since the last load request.
    logic [CNT_W-1:0] pulse_cnt;
    always_ff @(posedge clk) begin
        if (rst || go) pulse_cnt <= '0;
        else if (sclk) pulse_cnt <= pulse_cnt + 1'b1;
    end

    // R2
    line_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (pulse_cnt == CNT_W'(LINE_BITS - 1)));
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdata));
    // R3
    sclk_half_rate_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

endmodule

// File: rtl/mtx_pwm_timer.sv
module mtx_pwm_timer #(
    parameter int unsigned GS_BITS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic gsclk,
    output logic busy
);
    localparam int unsigned PULSES = 1 << GS_BITS;
    localparam int unsigned CW     = GS_BITS + 1;

    logic               ph;
    logic [GS_BITS-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ph    <= 1'b0;
            cnt   <= '0;
            gsclk <= 1'b0;
        end else if (go) begin
            busy  <= 1'b1;
            ph    <= 1'b0;
            cnt   <= '0;
            gsclk <= 1'b0;
        end else if (busy) begin
            ph    <= ~ph;
            gsclk <= ph;
            if (ph) begin
                cnt <= cnt + 1'b1;
                if (cnt == '1) busy <= 1'b0;
            end
        end else begin
            gsclk <= 1'b0;
        end
    end

    // Checker state: greyscale pulses within the current window.
    logic [CW-1:0] seen;
    always_ff @(posedge clk) begin
        if (rst || go) seen <= '0;
        else if (gsclk) seen <= seen + 1'b1;
    end

    // R6
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (gsclk && seen == CW'(PULSES - 1)));
    // R6
    gs_half_rate_chk: assert property (@(posedge clk) disable iff (rst)
        gsclk |=> !gsclk);

endmodule

// File: rtl/mtx_row_drive.sv
module mtx_row_drive #(
    parameter int unsigned NUM_ROWS = 4,
    localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ROW_W-1:0]    row_sel,
    output logic [NUM_ROWS-1:0] row_en_n
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) row_en_n[r] <= 1'b1;
            else if (load) row_en_n[r] <= (row_sel != ROW_W'(r));
        end
    end

    // R7
    one_row_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~row_en_n) <= 1);

endmodule

// File: rtl/mtx_refresh_top.sv
module mtx_refresh_top
    import mtx_refresh_pkg::*;
#(
    parameter int unsigned NUM_BANKS    = 3,
    parameter int unsigned DRV_PER_LINE = 3,
    parameter int unsigned CH_PER_DRV   = 16,
    parameter int unsigned GS_BITS      = 12,
    parameter int unsigned NUM_ROWS     = 4,
    localparam int unsigned LANES        = NUM_BANKS * LANES_PER_BANK,
    localparam int unsigned PIX_PER_LINE = DRV_PER_LINE * CH_PER_DRV,
    localparam int unsigned PIX_W        = $clog2(PIX_PER_LINE),
    localparam int unsigned ROW_W        = $clog2(NUM_ROWS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic [ROW_W+PIX_W-1:0]   pix_addr,
    input  logic [LANES*GS_BITS-1:0] pix_data,
    output logic                     sclk,
    output logic [LANES-1:0]         sdata,
    output logic                     gsclk,
    output logic                     blank,
    output logic                     xlat,
    output logic [NUM_ROWS-1:0]      row_en_n,
    output logic                     frame_done
);
    seq_state_e       state;
    logic [HC_W-1:0]  hc;
    logic [ROW_W-1:0] load_row;
    logic [PIX_W-1:0] pix_idx;
    strobe_t          strb;
    logic             sh_go, pw_go, row_load;
    logic             sh_done, pw_busy;

    assign pix_addr = {load_row, pix_idx};

    always_comb begin
        strb.blank = (state != SEQ_RUN);
        strb.xlat  = (state == SEQ_HAND) && xlat_window(hc);
        pw_go      = (state == SEQ_HAND) && (hc == HC_W'(HAND_LAST));
        sh_go      = pw_go || ((state == SEQ_IDLE) && start);
        row_load   = (state == SEQ_HAND) && (hc == HC_W'(HAND_ROW_SW - 1));
    end

    assign blank = strb.blank;
    assign xlat  = strb.xlat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            hc         <= '0;
            load_row   <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state    <= SEQ_FILL;
                        load_row <= '0;
                    end
                end
                SEQ_FILL: begin
                    if (sh_done) begin
                        state <= SEQ_HAND;
                        hc    <= '0;
                    end
                end
                SEQ_HAND: begin
                    hc <= hc + 1'b1;
                    if (hc == HC_W'(HAND_LAST)) begin
                        state      <= SEQ_RUN;
                        frame_done <= (load_row == ROW_W'(NUM_ROWS - 1));
                        load_row   <= ROW_W'(wrap_next(32'(load_row), NUM_ROWS));
                    end
                end
                SEQ_RUN: begin
                    if (!pw_busy && sh_done) begin
                        state <= SEQ_HAND;
                        hc    <= '0;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    mtx_shift_engine #(
        .LINES        (LANES),
        .GS_BITS      (GS_BITS),
        .PIX_PER_LINE (PIX_PER_LINE)
    ) shift_i (
        .clk       (clk),
        .rst       (rst),
        .go        (sh_go),
        .lane_word (pix_data),
        .pix_idx   (pix_idx),
        .sclk      (sclk),
        .sdata     (sdata),
        .done      (sh_done)
    );

    mtx_pwm_timer #(
        .GS_BITS (GS_BITS)
    ) pwm_i (
        .clk   (clk),
        .rst   (rst),
        .go    (pw_go),
        .gsclk (gsclk),
        .busy  (pw_busy)
    );

    mtx_row_drive #(
        .NUM_ROWS (NUM_ROWS)
    ) rows_i (
        .clk      (clk),
        .rst      (rst),
        .load     (row_load),
        .row_sel  (load_row),
        .row_en_n (row_en_n)
    );

    // R5
    xlat_blank_chk: assert property (@(posedge clk) disable iff (rst)
        xlat |-> blank);
    // R5
    xlat_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xlat) |=> (xlat && blank));
    // R5
    xlat_close_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xlat) |-> ($past(xlat, 2) && !$past(xlat, 3) && blank));
    // R4
    row_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_en_n) |-> (blank && $past(blank)));
    // R4
    unblank_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> (!$past(xlat) && !$past(row_en_n == '1)));
    // R6
    gs_blank_chk: assert property (@(posedge clk) disable iff (rst)
        blank |-> !gsclk);
    // R8
    frame_done_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!row_en_n[NUM_ROWS-1] && !blank));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE) |-> (blank && !sclk && !gsclk));
    // R11
    load_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(blank) |-> $past(sh_done));

endmodule

// File: tb/mtx_refresh_top_tb_top.sv
`timescale 1ns/1ps
module mtx_refresh_top_tb_top;
    localparam int NB     = 3;
    localparam int LANES  = NB * 3;
    localparam int GS     = 12;
    localparam int PIX    = 48;
    localparam int NR     = 4;
    localparam int ROW_W  = 2;
    localparam int PIX_W  = 6;
    localparam int LBITS  = PIX * GS;
    localparam int SH_END = 2 * LBITS;
    localparam int PULSES = 4096;
    localparam int RUN_END = 2 * PULSES;
    localparam int PH_IDLE = 0, PH_FILL = 1, PH_HAND = 2, PH_RUN = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [ROW_W+PIX_W-1:0] pix_addr;
    logic [LANES*GS-1:0]    pix_data;
    logic sclk, gsclk, blank, xlat, frame_done;
    logic [LANES-1:0] sdata;
    logic [NR-1:0]    row_en_n;

    always #10 clk = ~clk;

    mtx_refresh_top dut_i (
        .clk(clk), .rst(rst), .start(start), .pix_addr(pix_addr),
        .pix_data(pix_data), .sclk(sclk), .sdata(sdata), .gsclk(gsclk),
        .blank(blank), .xlat(xlat), .row_en_n(row_en_n), .frame_done(frame_done)
    );

    int total = 0, bad = 0;
    int pat_sel = 0;
    bit finished = 1'b0;

    function automatic logic [GS-1:0] pat(int sel, int lane, int row, int pix);
        int v;
        case (sel)
            0:       v = (pix * 37 + row * 1000 + lane * 229 + 165) * 13;
            1:       v = (pix == 0 && row == lane % NR) ? 4095 : 0;
            default: v = 1 << ((pix + lane + row) % GS);
        endcase
        return v[GS-1:0];
    endfunction

    always_comb begin
        for (int l = 0; l < LANES; l++)
            pix_data[l*GS +: GS] = pat(pat_sel, l, int'(pix_addr[PIX_W +: ROW_W]),
                                       int'(pix_addr[PIX_W-1:0]));
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model state
    int phase = PH_IDLE, pos = 0, ld_row = 0, dp_row = 0;
    bit dp_valid = 1'b0;
    logic [LANES-1:0] e_sdata = '0;
    int sclk_cnt = 0, gs_cnt = 0, fd_count = 0, ho_count = 0, stray_win = 0, cyc = 0;
    logic prev_blank = 1'b1, prev_xlat = 1'b0, rst_seen = 1'b1;

    always @(posedge clk) rst_seen <= rst;

    task automatic report_and_end();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        logic e_blank, e_xlat, e_sclk, e_gs, e_fd;
        logic [NR-1:0] e_row;
        logic [GS-1:0] w;
        bit sh_ph;
        int i, px, bt;
        cyc++;
        if (!finished && cyc > 150000) begin
            chk(1'b0, "R11", "watchdog expired", cyc, 150000);
            report_and_end();
        end
        if (finished) begin
        end else if (rst_seen) begin
            // R1 reset values
            chk(blank === 1'b1, "R1", "blank in reset", blank, 1);
            chk(xlat === 1'b0 && sclk === 1'b0 && gsclk === 1'b0, "R1", "strobes in reset",
                {xlat, sclk, gsclk}, 0);
            chk(row_en_n === '1, "R1", "rows released in reset", row_en_n, 4'hF);
            chk(frame_done === 1'b0 && sdata === '0, "R1", "frame_done/sdata in reset",
                {frame_done, sdata}, 0);
            phase = PH_IDLE; pos = 0; ld_row = 0; dp_row = 0; dp_valid = 0;
            e_sdata = '0; sclk_cnt = 0; gs_cnt = 0;
            prev_blank = 1'b1; prev_xlat = 1'b0;
        end else begin
            sh_ph = (phase == PH_FILL || phase == PH_RUN);
            if (sh_ph && pos >= 1 && pos < SH_END && pos % 2 == 1) begin
                i  = (pos - 1) / 2;
                px = PIX - 1 - i / GS;
                bt = GS - 1 - i % GS;
                for (int l = 0; l < LANES; l++) begin
                    w = pat(pat_sel, l, ld_row, px);
                    e_sdata[l] = w[bt];
                end
            end
            e_sclk  = sh_ph && pos >= 2 && pos <= SH_END && pos % 2 == 0;
            e_gs    = (phase == PH_RUN) && pos >= 2 && pos % 2 == 0;
            e_blank = (phase != PH_RUN);
            e_xlat  = (phase == PH_HAND) && (pos == 1 || pos == 2);
            if (phase == PH_HAND && pos == 3) begin dp_row = ld_row; dp_valid = 1; end
            e_row = '1;
            if (dp_valid) e_row[dp_row] = 1'b0;
            e_fd = (phase == PH_RUN) && pos == 0 && dp_row == NR - 1;

            chk(blank === e_blank, "R4", "blank", blank, e_blank);
            chk(xlat === e_xlat, "R5", "xlat", xlat, e_xlat);
            chk(sclk === e_sclk, "R3", "sclk", sclk, e_sclk);
            chk(sdata === e_sdata, "R2 R9", "sdata lanes", sdata, e_sdata);
            chk(gsclk === e_gs, "R6", "gsclk", gsclk, e_gs);
            chk(row_en_n === e_row, "R7 R8", "row enables", row_en_n, e_row);
            chk(frame_done === e_fd, "R8", "frame_done", frame_done, e_fd);
            if (stray_win > 0) begin
                stray_win--;
                chk(blank === e_blank && sclk === e_sclk && gsclk === e_gs && row_en_n === e_row,
                    "R10", "start during refresh", {blank, sclk, gsclk, row_en_n},
                    {e_blank, e_sclk, e_gs, e_row});
            end
            if (phase == PH_IDLE)
                chk(blank === 1'b1 && sclk === 1'b0 && gsclk === 1'b0, "R10", "idle quiet",
                    {blank, sclk, gsclk}, 3'b100);

            // Independent pulse counts
            if (sclk === 1'b1) sclk_cnt++;
            if (gsclk === 1'b1) gs_cnt++;
            if (xlat === 1'b1 && prev_xlat !== 1'b1) begin
                chk(sclk_cnt == LBITS, "R11", "shift pulses before latch", sclk_cnt, LBITS);
                sclk_cnt = 0;
                ho_count++;
            end
            if (blank === 1'b1 && prev_blank !== 1'b1) begin
                chk(gs_cnt == PULSES, "R6", "gsclk pulses per window", gs_cnt, PULSES);
                gs_cnt = 0;
            end
            if (frame_done === 1'b1) fd_count++;
            prev_blank = blank;
            prev_xlat  = xlat;

            // Advance the timeline
            case (phase)
                PH_IDLE: if (start) begin phase = PH_FILL; pos = 0; ld_row = 0; end
                PH_FILL: if (pos == SH_END) begin phase = PH_HAND; pos = 0; end else pos++;
                PH_HAND: if (pos == 4) begin
                             phase = PH_RUN; pos = 0; ld_row = (ld_row + 1) % NR;
                         end else pos++;
                default: if (pos == RUN_END) begin
                             phase = PH_HAND; pos = 0; pat_sel = (pat_sel + 1) % 3;
                         end else pos++;
            endcase
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        repeat (20) @(posedge clk);
        #2 start = 1'b1;
        @(posedge clk);
        #2 start = 1'b0;
        while (fd_count < 1) @(posedge clk);
        // stray start while refreshing
        #2 start = 1'b1;
        stray_win = 24;
        @(posedge clk);
        #2 start = 1'b0;
        while (ho_count < 7) @(posedge clk);
        repeat (3000) @(posedge clk);
        chk(fd_count == 1, "R8", "frame pulses after seven handovers", fd_count, 1);
        // reset in the middle of a PWM window
        #2 rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        report_and_end();
    end

endmodule